// File: doc/BRIEF.md
# Microcode Sequencer with Packed Control Store

This block steps through micro-programs for a microcoded processor. When it is idle and a new machine opcode arrives, the opcode is latched and picks a fixed slot of 16 micro-instructions in the control store, starting at slot entry 0. A 4-bit micro-counter then walks the slot. A short instruction simply runs to its end marker without any jump. A conditional micro-jump may redirect the counter to another entry of the same slot, depending on one of eight condition inputs.

The control store holds 512 micro-instructions of 21 bits each. They are packed four to a physical 84-bit row, which gives 128 rows. The row address is the opcode followed by the top two bits of the micro-counter. The bottom two counter bits pick which 21-bit quarter of the row is executed.

Each executed micro-instruction is decoded into registered source, destination, ALU and flag-update controls. These appear in the cycle after the micro-instruction was addressed. Micro-instructions whose type has its top bit set use a second field layout, which carries an 8-bit miscellaneous code in place of an ALU operation.

Top module: `mcs_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `busy_o`, `valid_o` and every control output are 0.
- R2: `start_i` is accepted only while `busy_o` is 0. On acceptance `opcode_i` is latched and `busy_o` rises at that edge. While busy, `start_i` and `opcode_i` have no effect on the running micro-program.
- R3: The first micro-instruction executed after acceptance is slot entry 0 of the slot for the latched opcode (store address opcode*16). Store address `a` lives in row `a>>2`, at bits `[(a%4)*21 +: 21]` of that 84-bit row.
- R4: Micro-instruction bits are: source [20:16], destination [15:11], type [10:9], A [8:4], B [3:1], flag enable [0]. `src_o` and `dst_o` show the source and destination fields of every executed micro-instruction.
- R5: After an executed micro-instruction that is neither a taken jump nor an end marker, the counter advances by one.
- R6: Type 0 is a conditional jump. If `cond_i[B]` is 1, the next entry is A[3:0] of the same slot and `jump_taken_o` is 1. If it is 0, the counter advances by one and `jump_taken_o` is 0. A jump sets no ALU or miscellaneous enable.
- R7: Type 1 is an ALU operation: `alu_en_o`=1, `alu_op_o`=A, `flag_we_o`=flag enable bit. For every other type, `alu_en_o`, `alu_op_o` and `flag_we_o` are 0.
- R8: Types 2 and 3 (type bit 1 set) use the second layout: `misc_en_o`=1 and `misc_code_o`={A,B}. For types 0 and 1 both are 0.
- R9: Type 3 with B=7 is the end marker. `end_o` pulses with its decoded controls, and the sequencer is idle (`busy_o`=0) from the same edge on.
- R10: Decoded controls are registered. `valid_o` is 1 exactly in the cycles after an edge at which a micro-instruction executed, and all controls are 0 when `valid_o` is 0.
- R11: The built-in program for opcode p, with L=4+(p%8), is as follows. Entries >= L are end markers with A=p and source and destination 0. For odd p, entry 1 is a jump with source 1, destination p, B=(p>>1)%8 and A=L-1. For p%4==2, entry 2 is type 2 with A=p, B=2, source 2 and destination p. Every other entry i is type 1 with source (p+i)%32, destination (p+3i)%32, A=p^i, B=i%8 and flag enable i%2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to start a new opcode |
| opcode_i | input | 5 | Machine opcode selecting the slot |
| cond_i | input | 8 | Condition inputs for micro-jumps |
| busy_o | output | 1 | Sequencer is running a micro-program |
| valid_o | output | 1 | Decoded controls are valid this cycle |
| src_o | output | 5 | Decoded source field |
| dst_o | output | 5 | Decoded destination field |
| alu_en_o | output | 1 | ALU operation present |
| alu_op_o | output | 5 | ALU opcode |
| flag_we_o | output | 1 | Status-flag update enable |
| misc_en_o | output | 1 | Second-layout micro-instruction present |
| misc_code_o | output | 8 | Second-layout code {A,B} |
| jump_taken_o | output | 1 | A conditional jump was taken |
| end_o | output | 1 | End marker executed |

## Verification
A wrong micro-counter or a wrong quarter select shows up within one cycle as a wrong source, destination or opcode field on the control outputs, because every slot entry of the built-in program carries different field values. A lost end marker or a bad jump target shows as a sequence that departs from the expected walk of the slot, and `busy_o` then stays high past the expected end. The sweep runs all 32 opcodes under four condition patterns, with start requests held high during some runs, so every slot, quarter and jump outcome is visited.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int SRC_W = 5;
  localparam int DST_W = 5;
  localparam int TYP_W = 2;
  localparam int A_W   = 5;
  localparam int B_W   = 3;
  localparam int UW    = SRC_W + DST_W + TYP_W + A_W + B_W + 1;

  localparam logic [TYP_W-1:0] TYP_JUMP = 2'd0;
  localparam logic [TYP_W-1:0] TYP_ALU  = 2'd1;
  localparam logic [TYP_W-1:0] TYP_MISC = 2'd2;
  localparam logic [TYP_W-1:0] TYP_TERM = 2'd3;
  localparam logic [B_W-1:0]   B_END    = '1;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic [TYP_W-1:0] typ;
    logic [A_W-1:0]   a;
    logic [B_W-1:0]   b;
    logic             f;
  } uword_t;

  // Built-in micro-program: entry idx of the slot for opcode op.
  function automatic uword_t program_word(input int op, input int idx);
    uword_t w;
    int     len;
    len = 4 + (op % 8);
    w   = '0;
    if (idx >= len) begin
      w.typ = TYP_TERM;
      w.a   = A_W'(op);
      w.b   = B_END;
    end else if (idx == 1 && (op % 2) == 1) begin
      w.typ = TYP_JUMP;
      w.src = SRC_W'(idx);
      w.dst = DST_W'(op);
      w.b   = B_W'((op / 2) % 8);
      w.a   = A_W'(len - 1);
    end else if (idx == 2 && (op % 4) == 2) begin
      w.typ = TYP_MISC;
      w.src = SRC_W'(idx);
      w.dst = DST_W'(op);
      w.a   = A_W'(op);
      w.b   = B_W'(2);
    end else begin
      w.typ = TYP_ALU;
      w.src = SRC_W'((op + idx) % 32);
      w.dst = DST_W'((op + 3 * idx) % 32);
      w.a   = A_W'(op ^ idx);
      w.b   = B_W'(idx % 8);
      w.f   = (idx % 2) == 1;
    end
    return w;
  endfunction
endpackage

// File: rtl/mcs_store.sv
module mcs_store
  import mcs_pkg::*;
#(
  parameter int OPC_W     = 5,
  parameter int SLOT_LOG2 = 4,
  parameter int PACK_LOG2 = 2
) (
  input  logic [OPC_W-1:0]     op_i,
  input  logic [SLOT_LOG2-1:0] upc_i,
  output uword_t               word_o
);
  localparam int ROW_AW  = OPC_W + SLOT_LOG2 - PACK_LOG2;
  localparam int ROWS    = 1 << ROW_AW;
  localparam int PACKN   = 1 << PACK_LOG2;
  localparam int ROW_W   = UW * PACKN;
  localparam int RPS     = 1 << (SLOT_LOG2 - PACK_LOG2);

  typedef logic [ROWS-1:0][ROW_W-1:0] image_t;

  function automatic image_t build_image();
    image_t img;
    img = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int q = 0; q < PACKN; q++) begin
        img[r][q*UW +: UW] = program_word(r / RPS, (r % RPS) * PACKN + q);
      end
    end
    return img;
  endfunction

  localparam image_t IMAGE = build_image();

  logic [ROW_AW-1:0]    row_addr;
  logic [PACK_LOG2-1:0] qsel;
  logic [ROW_W-1:0]     row_w;
  uword_t               quarter_w [PACKN];

  assign row_addr = {op_i, upc_i[SLOT_LOG2-1:PACK_LOG2]};
  assign qsel     = upc_i[PACK_LOG2-1:0];
  assign row_w    = IMAGE[row_addr];

  for (genvar g = 0; g < PACKN; g++) begin : g_quarter
    assign quarter_w[g] = uword_t'(row_w[g*UW +: UW]);
  end

  assign word_o = quarter_w[qsel];
endmodule

// File: rtl/mcs_counter.sv
module mcs_counter
  import mcs_pkg::*;
#(
  parameter int OPC_W     = 5,
  parameter int SLOT_LOG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [OPC_W-1:0]       opcode_i,
  input  logic [(1<<B_W)-1:0]    cond_i,
  input  logic [TYP_W-1:0]       typ_i,
  input  logic [B_W-1:0]         b_i,
  input  logic [SLOT_LOG2-1:0]   tgt_i,
  output logic                   run_o,
  output logic [OPC_W-1:0]       op_o,
  output logic [SLOT_LOG2-1:0]   upc_o,
  output logic                   fin_o,
  output logic                   taken_o
);
  logic                 run_q, run_d;
  logic [OPC_W-1:0]     op_q;
  logic                 op_en;
  logic [SLOT_LOG2-1:0] upc_q, upc_d;
  logic                 fin, taken;

  always_comb begin
    run_d = run_q;
    upc_d = upc_q;
    op_en = 1'b0;
    fin   = 1'b0;
    taken = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        upc_d = '0;
        op_en = 1'b1;
      end
    end else begin
      fin   = (typ_i == TYP_TERM) && (b_i == B_END);
      taken = (typ_i == TYP_JUMP) && cond_i[b_i];
      if (fin) begin
        run_d = 1'b0;
        upc_d = '0;
      end else if (taken) begin
        upc_d = tgt_i;
      end else begin
        upc_d = upc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      upc_q <= '0;
    end else begin
      run_q <= run_d;
      upc_q <= upc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= '0;
    else if (op_en) op_q <= opcode_i;
  end

  assign run_o   = run_q;
  assign op_o    = op_q;
  assign upc_o   = upc_q;
  assign fin_o   = fin;
  assign taken_o = taken;

  // R2: the latched opcode cannot change while a micro-program runs
  p_hold_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(op_q));
  // R2, R3: an accepted start begins at slot entry 0
  p_start_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start_i) |=> (run_q && upc_q == '0));
  // R5: plain micro-instructions advance the counter by one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !fin && !taken) |=> (upc_q == $past(upc_q) + 1'b1));
  // R6: a taken jump loads the target entry
  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (upc_q == $past(tgt_i)));
  // R9: the end marker returns to idle
  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !run_q);
endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  uword_t           word_i,
  input  logic             fin_i,
  input  logic             taken_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o,
  output logic [DST_W-1:0] dst_o,
  output logic             alu_en_o,
  output logic [A_W-1:0]   alu_op_o,
  output logic             flag_we_o,
  output logic             misc_en_o,
  output logic [A_W+B_W-1:0] misc_code_o,
  output logic             jump_taken_o,
  output logic             end_o
);
  logic               valid_d, valid_q;
  logic [SRC_W-1:0]   src_d, src_q;
  logic [DST_W-1:0]   dst_d, dst_q;
  logic               alu_en_d, alu_en_q;
  logic [A_W-1:0]     alu_op_d, alu_op_q;
  logic               flag_d, flag_q;
  logic               misc_en_d, misc_en_q;
  logic [A_W+B_W-1:0] misc_d, misc_q;
  logic               jump_d, jump_q;
  logic               end_d, end_q;

  always_comb begin
    valid_d   = 1'b0;
    src_d     = '0;
    dst_d     = '0;
    alu_en_d  = 1'b0;
    alu_op_d  = '0;
    flag_d    = 1'b0;
    misc_en_d = 1'b0;
    misc_d    = '0;
    jump_d    = 1'b0;
    end_d     = 1'b0;
    if (exec_i) begin
      valid_d = 1'b1;
      src_d   = word_i.src;
      dst_d   = word_i.dst;
      jump_d  = taken_i;
      end_d   = fin_i;
      if (word_i.typ == TYP_ALU) begin
        alu_en_d = 1'b1;
        alu_op_d = word_i.a;
        flag_d   = word_i.f;
      end
      if (word_i.typ[TYP_W-1]) begin
        misc_en_d = 1'b1;
        misc_d    = {word_i.a, word_i.b};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      alu_en_q  <= 1'b0;
      alu_op_q  <= '0;
      flag_q    <= 1'b0;
      misc_en_q <= 1'b0;
      misc_q    <= '0;
      jump_q    <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      src_q     <= src_d;
      dst_q     <= dst_d;
      alu_en_q  <= alu_en_d;
      alu_op_q  <= alu_op_d;
      flag_q    <= flag_d;
      misc_en_q <= misc_en_d;
      misc_q    <= misc_d;
      jump_q    <= jump_d;
      end_q     <= end_d;
    end
  end

  assign valid_o      = valid_q;
  assign src_o        = src_q;
  assign dst_o        = dst_q;
  assign alu_en_o     = alu_en_q;
  assign alu_op_o     = alu_op_q;
  assign flag_we_o    = flag_q;
  assign misc_en_o    = misc_en_q;
  assign misc_code_o  = misc_q;
  assign jump_taken_o = jump_q;
  assign end_o        = end_q;

  // R10: controls follow execution by exactly one cycle
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> valid_q);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> (!valid_q && !alu_en_q && !misc_en_q && !end_q));
  // R7, R8: the two field layouts never decode at once
  p_layout_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alu_en_q, misc_en_q, jump_q}));
  // R7: flag update only comes with an ALU operation
  p_flag_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> alu_en_q);
  // R9: the end marker decodes in the second layout
  p_end_misc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (misc_en_q && valid_q));
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int OPC_W     = 5,
  parameter int SLOT_LOG2 = 4,
  parameter int PACK_LOG2 = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [OPC_W-1:0]       opcode_i,
  input  logic [(1<<B_W)-1:0]    cond_i,
  output logic                   busy_o,
  output logic                   valid_o,
  output logic [SRC_W-1:0]       src_o,
  output logic [DST_W-1:0]       dst_o,
  output logic                   alu_en_o,
  output logic [A_W-1:0]         alu_op_o,
  output logic                   flag_we_o,
  output logic                   misc_en_o,
  output logic [A_W+B_W-1:0]     misc_code_o,
  output logic                   jump_taken_o,
  output logic                   end_o
);
  logic                 run;
  logic [OPC_W-1:0]     op;
  logic [SLOT_LOG2-1:0] upc;
  logic                 fin, taken;
  uword_t               word;

  mcs_counter #(.OPC_W(OPC_W), .SLOT_LOG2(SLOT_LOG2)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .cond_i   (cond_i),
    .typ_i    (word.typ),
    .b_i      (word.b),
    .tgt_i    (word.a[SLOT_LOG2-1:0]),
    .run_o    (run),
    .op_o     (op),
    .upc_o    (upc),
    .fin_o    (fin),
    .taken_o  (taken)
  );

  mcs_store #(.OPC_W(OPC_W), .SLOT_LOG2(SLOT_LOG2), .PACK_LOG2(PACK_LOG2)) u_store (
    .op_i   (op),
    .upc_i  (upc),
    .word_o (word)
  );

  mcs_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (run),
    .word_i       (word),
    .fin_i        (fin),
    .taken_i      (taken),
    .valid_o      (valid_o),
    .src_o        (src_o),
    .dst_o        (dst_o),
    .alu_en_o     (alu_en_o),
    .alu_op_o     (alu_op_o),
    .flag_we_o    (flag_we_o),
    .misc_en_o    (misc_en_o),
    .misc_code_o  (misc_code_o),
    .jump_taken_o (jump_taken_o),
    .end_o        (end_o)
  );

  assign busy_o = run;

  // R9: an end pulse is never seen while still busy
  p_end_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !busy_o);
endmodule

// File: tb/tb_mcs_sequencer.sv
`timescale 1ns/1ps
module tb_mcs_sequencer;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [4:0] opcode_i;
  logic [7:0] cond_i;
  logic       busy_o, valid_o, alu_en_o, flag_we_o, misc_en_o, jump_taken_o, end_o;
  logic [4:0] src_o, dst_o, alu_op_o;
  logic [7:0] misc_code_o;

  int checks = 0;
  int errors = 0;

  mcs_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i), .cond_i(cond_i),
    .busy_o(busy_o), .valid_o(valid_o), .src_o(src_o), .dst_o(dst_o),
    .alu_en_o(alu_en_o), .alu_op_o(alu_op_o), .flag_we_o(flag_we_o),
    .misc_en_o(misc_en_o), .misc_code_o(misc_code_o),
    .jump_taken_o(jump_taken_o), .end_o(end_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {3'b0, valid_o, src_o, dst_o, alu_en_o, alu_op_o, flag_we_o,
            misc_en_o, misc_code_o, jump_taken_o, end_o};
  endfunction

  // Expected outputs of entry idx of opcode op (R11 program, R4/R6-R9 decode).
  task automatic expect_entry(input int op, input int idx, input logic [7:0] cp,
                              output logic [31:0] exp, output bit fin,
                              output int nidx, output string tag);
    int L, s, d, a, b, f, kind;
    bit tk;
    L = 4 + op % 8;
    tk = 0; fin = 0;
    if (idx >= L) begin kind = 3; s = 0; d = 0; a = op; b = 7; f = 0; end
    else if (idx == 1 && op % 2 == 1) begin kind = 0; s = 1; d = op; a = L - 1; b = (op / 2) % 8; f = 0; end
    else if (idx == 2 && op % 4 == 2) begin kind = 2; s = 2; d = op; a = op; b = 2; f = 0; end
    else begin kind = 1; s = (op + idx) % 32; d = (op + 3 * idx) % 32; a = op ^ idx; b = idx % 8; f = idx % 2; end
    exp = 0;
    exp[28]    = 1'b1;
    exp[27:23] = 5'(s);
    exp[22:18] = 5'(d);
    nidx = idx + 1;
    case (kind)
      0: begin tk = cp[b]; exp[1] = tk; if (tk) nidx = a % 16; tag = "R6 R3 R4"; end
      1: begin exp[17] = 1; exp[16:12] = 5'(a); exp[11] = f[0]; tag = "R7 R5 R4"; end
      2: begin exp[10] = 1; exp[9:2] = {5'(a), 3'(b)}; tag = "R8 R4"; end
      default: begin exp[10] = 1; exp[9:2] = {5'(a), 3'(b)}; exp[0] = 1; fin = 1; tag = "R9 R11"; end
    endcase
  endtask

  task automatic run_prog(input int op, input logic [7:0] cp, input bit noise);
    logic [31:0] exp;
    bit fin;
    int idx, nidx, steps;
    string tag;
    @(negedge clk);
    check("R2 idle before start", {31'b0, busy_o}, 32'd0);
    start_i = 1'b1; opcode_i = 5'(op); cond_i = cp;
    @(negedge clk);
    if (noise) begin start_i = 1'b1; opcode_i = ~5'(op); end
    else start_i = 1'b0;
    check("R2 busy after accept", {30'b0, busy_o, valid_o}, 32'd2);
    idx = 0; fin = 0; steps = 0;
    while (!fin && steps < 20) begin
      @(negedge clk);
      expect_entry(op, idx, cp, exp, fin, nidx, tag);
      if (fin) start_i = 1'b0;
      check(noise ? {tag, " R2 R10 busy-noise"} : {tag, " R10"}, outs(), exp);
      check("R9 busy", {31'b0, busy_o}, {31'b0, !fin});
      idx = nidx; steps++;
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R10 R9 idle quiet", outs(), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hAA;
    rst_n = 1'b0; start_i = 1'b0; opcode_i = '0; cond_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 32'd0);
    check("R1 reset busy", {31'b0, busy_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {outs()[30:0], busy_o}, 32'd0);
    for (int pi = 0; pi < 4; pi++) begin
      for (int op = 0; op < 32; op++) begin
        run_prog(op, pats[pi], (op % 3) == 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule